// File: doc/BRIEF.md
# Cache-Mode Page Program Sequencer

This controller sits on the host side of a NAND flash bus. It writes a run of pages using the device's cached program mode, so that the bus transfer of the next page runs while the array is still busy with the one before. Each page request carries a row address and a flag that marks the final page of the run. The controller issues the load opcode, the address bytes and the page data, pulled one byte at a time from an external source, and then the confirm opcode. It then polls the status register to learn when the cache register can take new data and when the array has gone idle.

Status reports come in two kinds, and the controller tells them apart. A report that shows only the cache as free carries the pass/fail flag of the page before the one just confirmed. A report that shows the array as idle carries the flag of the page just confirmed. The controller keeps the earlier page outstanding until its flag comes back. It then emits one result per page, in the order the pages were submitted. A mode input chooses how a run ends. One choice confirms the final page with the cache opcode and polls until the array is idle. The other confirms it with the plain program opcode and waits on the ready/busy pin. A wait that never completes aborts the run.

Top module: `nand_cache_prog_ctrl`

## Requirements
- R1: Each page is sent in this order: command 0x80; five address bytes (two zero column bytes, then the row least significant byte first); PAGE_BYTES data writes, each with `dat_take` high and `bus_dout` equal to `dat_byte`; then one confirm command.
- R2: The confirm command is 0x15. The one exception is the page flagged last while `end_with_final` is 1, which is confirmed with 0x10.
- R3: After a 0x15 confirm, `req_ready` stays low and the controller polls status until bit 6 reads 1. Each poll is command 0x70 followed by one read cycle. No new load starts before bit 6 reads 1.
- R4: When bit 6 first reads 1 after a confirm, and an earlier page of the run is still without a result, that page's result is emitted with `res_fail` equal to status bit 0.
- R5: For a last page confirmed with 0x15, polling continues after bit 6 until bit 5 reads 1. The last page's result is then emitted with `res_fail` equal to bit 0.
- R6: For a last page confirmed with 0x10, the controller waits for `rb_n` low and then high, and then makes one poll. If an earlier page is outstanding, its result is emitted from bit 1. The last page's result follows in the next cycle, from bit 0.
- R7: Exactly one result is emitted per page, in submission order, with `res_row` equal to that page's row.
- R8: In a run of several pages, the next page's load starts while the array is still programming the previous page. The controller does not wait for bit 5 between pages.
- R9: After TMO_LIMIT consecutive failed polls or ready/busy wait cycles, `abort` pulses for one cycle. Outstanding results are dropped and the controller returns to accepting requests.
- R10: During reset `req_ready` is 1, while `res_valid`, `abort`, `dat_take` and `bus_op` are 0. The `bus_op` codes are 0 idle, 1 command, 2 address, 3 data write and 4 status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| end_with_final | input | 1 | 1: last page confirmed with 0x10 and ready/busy wait |
| req_valid | input | 1 | Page request present |
| req_ready | output | 1 | Controller accepts a request |
| req_row | input | ROW_W | Row address of the page |
| req_last | input | 1 | Page is the final one of the run |
| bus_op | output | 3 | Bus cycle kind (0 idle, 1 cmd, 2 addr, 3 write, 4 read) |
| bus_dout | output | 8 | Command, address or data byte |
| bus_din | input | 8 | Status byte, captured at the end of a read cycle |
| rb_n | input | 1 | Device ready/busy, low while busy |
| dat_take | output | 1 | Data byte consumed this cycle |
| dat_byte | input | 8 | Next page data byte from the source |
| res_valid | output | 1 | Page result valid |
| res_row | output | ROW_W | Row of the reported page |
| res_fail | output | 1 | 1 when the page failed to program |
| abort | output | 1 | One-cycle pulse on a readiness timeout |

## Verification
The bench drives a device model whose array program time is longer than a page load. A controller that waited for the array between pages would therefore never start a load during programming. The model sets different fail flags on neighbouring pages, so if the bit-0 value from a cache-ready report were credited to the page just confirmed instead of the one before it, every result would shift by one page. Single-page and two-page runs are run in both ending modes. They catch an emit that fires with no earlier page outstanding, and a final read that reports only one of two pages. A model that leaves the cache busy forever exercises the abort, and any result emitted after the abort counts as a failure.

// File: rtl/nand_cpp_pkg.sv
package nand_cpp_pkg;

    typedef enum logic [2:0] {
        BUS_IDLE = 3'd0,
        BUS_CMD  = 3'd1,
        BUS_ADDR = 3'd2,
        BUS_WR   = 3'd3,
        BUS_RD   = 3'd4
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD_CMD,
        S_ADDR,
        S_DATA,
        S_CONFIRM,
        S_ST_CMD,
        S_ST_RD,
        S_RB_LOW,
        S_RB_HIGH,
        S_EMIT_CUR
    } seq_state_e;

    // what the current status poll is waiting for
    typedef enum logic [1:0] {
        G_CACHE,
        G_ARRAY,
        G_FINAL
    } poll_goal_e;

    localparam logic [7:0] OPC_LOAD  = 8'h80;
    localparam logic [7:0] OPC_CACHE = 8'h15;
    localparam logic [7:0] OPC_FINAL = 8'h10;
    localparam logic [7:0] OPC_STAT  = 8'h70;

endpackage

// File: rtl/nand_cpp_addr_mux.sv
module nand_cpp_addr_mux #(
    parameter int ROW_W    = 24,
    parameter int ADDR_CYC = 5,
    parameter int COL_CYC  = 2,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [ROW_W-1:0] row,
    output logic [7:0]       addr_byte
);
    localparam int ROW_CYC = ADDR_CYC - COL_CYC;

    logic [ROW_CYC*8-1:0] row_pad;
    logic [7:0]           cyc_byte [ADDR_CYC];

    always_comb begin
        row_pad = '0;
        row_pad[ROW_W-1:0] = row;
    end

    for (genvar g = 0; g < ADDR_CYC; g++) begin : g_cyc
        if (g < COL_CYC) begin : g_col
            assign cyc_byte[g] = 8'h00;
        end else begin : g_row
            assign cyc_byte[g] = row_pad[(g-COL_CYC)*8 +: 8];
        end
    end

    always_comb begin
        addr_byte = 8'h00;
        for (int i = 0; i < ADDR_CYC; i++) begin
            if (idx == IDX_W'(i)) addr_byte = cyc_byte[i];
        end
    end
endmodule

// File: rtl/nand_cpp_status_decode.sv
module nand_cpp_status_decode #(
    parameter int CACHE_BIT = 6,
    parameter int ARRAY_BIT = 5,
    parameter int CUR_BIT   = 0,
    parameter int PREV_BIT  = 1
) (
    input  logic [7:0] stat,
    output logic       cache_rdy,
    output logic       array_rdy,
    output logic       fail_cur,
    output logic       fail_prev
);
    logic unused_stat;

    assign cache_rdy   = stat[CACHE_BIT];
    // array idle implies the cache is idle as well
    assign array_rdy   = stat[ARRAY_BIT] & stat[CACHE_BIT];
    assign fail_cur    = stat[CUR_BIT];
    assign fail_prev   = stat[PREV_BIT];
    assign unused_stat = ^stat;
endmodule

// File: rtl/nand_cpp_timeout.sv
module nand_cpp_timeout #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign expired = tick && !clear && (cnt_q == W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear || expired) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nand_cache_prog_ctrl.sv
module nand_cache_prog_ctrl
    import nand_cpp_pkg::*;
#(
    parameter int ROW_W      = 24,
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_CYC   = 5,
    parameter int COL_CYC    = 2,
    parameter int TMO_LIMIT  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             end_with_final,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_last,
    output logic [2:0]       bus_op,
    output logic [7:0]       bus_dout,
    input  logic [7:0]       bus_din,
    input  logic             rb_n,
    output logic             dat_take,
    input  logic [7:0]       dat_byte,
    output logic             res_valid,
    output logic [ROW_W-1:0] res_row,
    output logic             res_fail,
    output logic             abort
);
    localparam int CNT_MAX = (PAGE_BYTES > ADDR_CYC) ? PAGE_BYTES : ADDR_CYC;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    typedef struct packed {
        seq_state_e       st;
        poll_goal_e       goal;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] cur_row;
        logic             cur_last;
        logic             cur_fin;
        logic [ROW_W-1:0] prev_row;
        logic             prev_v;
        logic             hold_fail;
        logic             res_valid;
        logic [ROW_W-1:0] res_row;
        logic             res_fail;
        logic             abort;
    } ctl_t;

    ctl_t q, n;

    logic       cache_rdy, array_rdy, fail_cur, fail_prev;
    logic       poll_hit;
    logic       tmo_clear, tmo_tick, tmo_fire;
    logic [7:0] addr_byte;
    bus_op_e    op;

    nand_cpp_status_decode u_dec (
        .stat      (bus_din),
        .cache_rdy (cache_rdy),
        .array_rdy (array_rdy),
        .fail_cur  (fail_cur),
        .fail_prev (fail_prev)
    );

    nand_cpp_addr_mux #(
        .ROW_W    (ROW_W),
        .ADDR_CYC (ADDR_CYC),
        .COL_CYC  (COL_CYC),
        .IDX_W    (CNT_W)
    ) u_addr (
        .idx       (q.cnt),
        .row       (q.cur_row),
        .addr_byte (addr_byte)
    );

    always_comb begin
        unique case (q.goal)
            G_CACHE: poll_hit = cache_rdy;
            G_ARRAY: poll_hit = array_rdy;
            default: poll_hit = 1'b1;
        endcase
    end

    // timeout window spans every poll and ready/busy wait of one phase
    always_comb begin
        tmo_clear = (q.st == S_CONFIRM) || (q.st == S_ST_RD && poll_hit);
        tmo_tick  = (q.st == S_ST_RD && !poll_hit) ||
                    (q.st == S_RB_LOW && rb_n) ||
                    (q.st == S_RB_HIGH && !rb_n);
    end

    nand_cpp_timeout #(
        .LIMIT (TMO_LIMIT)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmo_clear),
        .tick    (tmo_tick),
        .expired (tmo_fire)
    );

    // next-state computation
    always_comb begin
        n           = q;
        n.res_valid = 1'b0;
        n.abort     = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    n.cur_row  = req_row;
                    n.cur_last = req_last;
                    n.cur_fin  = req_last && end_with_final;
                    n.st       = S_LOAD_CMD;
                end
            end
            S_LOAD_CMD: begin
                n.cnt = '0;
                n.st  = S_ADDR;
            end
            S_ADDR: begin
                if (q.cnt == CNT_W'(ADDR_CYC - 1)) begin
                    n.cnt = '0;
                    n.st  = S_DATA;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: begin
                if (q.cnt == CNT_W'(PAGE_BYTES - 1)) begin
                    n.cnt = '0;
                    n.st  = S_CONFIRM;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            S_CONFIRM: begin
                if (q.cur_fin) begin
                    n.st = S_RB_LOW;
                end else begin
                    n.st   = S_ST_CMD;
                    n.goal = G_CACHE;
                end
            end
            S_ST_CMD: begin
                n.st = S_ST_RD;
            end
            S_ST_RD: begin
                n.st = S_ST_CMD;
                unique case (q.goal)
                    G_CACHE: begin
                        if (cache_rdy) begin
                            // cache free: bit 0 belongs to the earlier page
                            if (q.prev_v) begin
                                n.res_valid = 1'b1;
                                n.res_row   = q.prev_row;
                                n.res_fail  = fail_cur;
                            end
                            if (q.cur_last) begin
                                n.prev_v = 1'b0;
                                n.goal   = G_ARRAY;
                            end else begin
                                n.prev_row = q.cur_row;
                                n.prev_v   = 1'b1;
                                n.st       = S_IDLE;
                            end
                        end
                    end
                    G_ARRAY: begin
                        if (array_rdy) begin
                            n.res_valid = 1'b1;
                            n.res_row   = q.cur_row;
                            n.res_fail  = fail_cur;
                            n.prev_v    = 1'b0;
                            n.st        = S_IDLE;
                        end
                    end
                    default: begin
                        if (q.prev_v) begin
                            n.res_valid = 1'b1;
                            n.res_row   = q.prev_row;
                            n.res_fail  = fail_prev;
                            n.hold_fail = fail_cur;
                            n.prev_v    = 1'b0;
                            n.st        = S_EMIT_CUR;
                        end else begin
                            n.res_valid = 1'b1;
                            n.res_row   = q.cur_row;
                            n.res_fail  = fail_cur;
                            n.st        = S_IDLE;
                        end
                    end
                endcase
            end
            S_RB_LOW: begin
                if (!rb_n) n.st = S_RB_HIGH;
            end
            S_RB_HIGH: begin
                if (rb_n) begin
                    n.st   = S_ST_CMD;
                    n.goal = G_FINAL;
                end
            end
            S_EMIT_CUR: begin
                n.res_valid = 1'b1;
                n.res_row   = q.cur_row;
                n.res_fail  = q.hold_fail;
                n.st        = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase

        if (tmo_fire) begin
            n           = q;
            n.st        = S_IDLE;
            n.prev_v    = 1'b0;
            n.res_valid = 1'b0;
            n.abort     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, goal: G_CACHE, default: '0};
        end else begin
            q <= n;
        end
    end

    // bus cycle decode
    always_comb begin
        op       = BUS_IDLE;
        bus_dout = 8'h00;
        dat_take = 1'b0;
        unique case (q.st)
            S_LOAD_CMD: begin op = BUS_CMD;  bus_dout = OPC_LOAD; end
            S_ADDR:     begin op = BUS_ADDR; bus_dout = addr_byte; end
            S_DATA:     begin op = BUS_WR;   bus_dout = dat_byte; dat_take = 1'b1; end
            S_CONFIRM:  begin op = BUS_CMD;  bus_dout = q.cur_fin ? OPC_FINAL : OPC_CACHE; end
            S_ST_CMD:   begin op = BUS_CMD;  bus_dout = OPC_STAT; end
            S_ST_RD:    begin op = BUS_RD; end
            default:    begin op = BUS_IDLE; end
        endcase
    end

    assign bus_op    = op;
    assign req_ready = (q.st == S_IDLE);
    assign res_valid = q.res_valid;
    assign res_row   = q.res_row;
    assign res_fail  = q.res_fail;
    assign abort     = q.abort;

endmodule

// File: rtl/nand_cpp_checker.sv
module nand_cpp_checker
    import nand_cpp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_op,
    input logic [7:0] bus_dout,
    input logic       req_ready,
    input logic       res_valid,
    input logic       abort
);
    // R1: load opcode is followed by an address cycle
    p_addr_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == BUS_CMD && bus_dout == OPC_LOAD) |=> (bus_op == BUS_ADDR));

    // R1: a confirm opcode directly follows a data write
    p_confirm_after_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == BUS_CMD && (bus_dout == OPC_CACHE || bus_dout == OPC_FINAL))
        |-> ($past(bus_op) == BUS_WR));

    // R3: every status read is preceded by the status command
    p_read_after_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == BUS_RD) |-> ($past(bus_op) == BUS_CMD && $past(bus_dout) == OPC_STAT));

    // R3: no request accepted right after a cache confirm
    p_busy_after_cache_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == BUS_CMD && bus_dout == OPC_CACHE) |=> !req_ready);

    // R7: results only follow a status read or another result
    p_result_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(bus_op) == BUS_RD || $past(res_valid)));

    // R9: abort is a single pulse, returns to idle, carries no result
    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (req_ready && !res_valid));

    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);
endmodule

bind nand_cache_prog_ctrl nand_cpp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_op    (bus_op),
    .bus_dout  (bus_dout),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .abort     (abort)
);

// File: tb/sim_nand_cache_prog_ctrl.sv
`timescale 1ns/1ps
module sim_nand_cache_prog_ctrl;
    import nand_cpp_pkg::*;

    localparam int PAGE  = 16;
    localparam int TMO   = 256;
    localparam int ARR_T = 60;
    localparam int XFER  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        end_with_final = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_row = '0;
    logic        req_last = 1'b0;
    logic [2:0]  bus_op;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din;
    logic        rb_n;
    logic        dat_take;
    logic [7:0]  dat_byte;
    logic        res_valid;
    logic [23:0] res_row;
    logic        res_fail;
    logic        abort;

    always #2.5 clk = ~clk;

    nand_cache_prog_ctrl #(
        .ROW_W(24), .PAGE_BYTES(PAGE), .ADDR_CYC(5), .COL_CYC(2), .TMO_LIMIT(TMO)
    ) u0 (.*);

    int checks = 0;
    int failures = 0;
    int results = 0;
    int aborts = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit fail_of(input logic [23:0] r);
        return (r % 3) == 1;
    endfunction

    // ---------------- device model ----------------
    int          arr_cnt, xfer_cnt, ld_ai, ld_data;
    bit          xfer_pend, arr_fail, pend_fail, last_fail, prev_fail, fin10, hang;
    bit          saw_overlap, data_bad;
    logic [7:0]  ld_addr [5];
    logic [23:0] drv_row;
    bit          drv_fin;
    logic [7:0]  dctr;
    logic        cache_busy;

    assign cache_busy = xfer_pend || (xfer_cnt != 0);
    assign bus_din = {1'b0, !cache_busy, !cache_busy && arr_cnt == 0, 3'b000, prev_fail, last_fail};
    assign rb_n = !(cache_busy || (fin10 && arr_cnt != 0));
    assign dat_byte = dctr;

    always @(posedge clk) begin
        if (!rst_n) dctr <= 8'h00;
        else if (dat_take) dctr <= dctr + 8'h01;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            arr_cnt <= 0; xfer_cnt <= 0; xfer_pend <= 0; fin10 <= 0;
            last_fail <= 0; prev_fail <= 0; ld_ai <= 0; ld_data <= 0; data_bad <= 0;
        end else begin
            if (arr_cnt != 0) begin
                arr_cnt <= arr_cnt - 1;
                if (arr_cnt == 1) begin
                    prev_fail <= last_fail;
                    last_fail <= arr_fail;
                end
            end
            if (xfer_pend && !hang && arr_cnt == 0) begin
                xfer_pend <= 0;
                xfer_cnt  <= XFER;
            end
            if (xfer_cnt != 0) begin
                xfer_cnt <= xfer_cnt - 1;
                if (xfer_cnt == 1) begin
                    arr_cnt  <= ARR_T;
                    arr_fail <= pend_fail;
                end
            end
            if (fin10 && !cache_busy && arr_cnt == 0) fin10 <= 0;
            case (bus_op)
                BUS_CMD: begin
                    if (bus_dout == OPC_LOAD) begin
                        ld_ai <= 0; ld_data <= 0; data_bad <= 0;
                        if (arr_cnt != 0) saw_overlap <= 1;
                        check(!cache_busy, "R3 load while cache busy", 32'(cache_busy), 0);
                    end else if (bus_dout == OPC_CACHE || bus_dout == OPC_FINAL) begin
                        check(bus_dout == (drv_fin ? OPC_FINAL : OPC_CACHE), "R2 confirm opcode",
                              32'(bus_dout), 32'(drv_fin ? OPC_FINAL : OPC_CACHE));
                        check(ld_addr[0] == 0 && ld_addr[1] == 0 &&
                              {ld_addr[4], ld_addr[3], ld_addr[2]} == drv_row && ld_ai == 5,
                              "R1 address bytes", {ld_addr[4], ld_addr[3], ld_addr[2]}, 32'(drv_row));
                        check(ld_data == PAGE && !data_bad, "R1 data count", 32'(ld_data), PAGE);
                        xfer_pend <= 1;
                        pend_fail <= fail_of({ld_addr[4], ld_addr[3], ld_addr[2]});
                        if (bus_dout == OPC_FINAL) fin10 <= 1;
                    end
                end
                BUS_ADDR: begin
                    if (ld_ai < 5) ld_addr[ld_ai] <= bus_dout;
                    ld_ai <= ld_ai + 1;
                end
                BUS_WR: begin
                    if (bus_dout != dctr || !dat_take) data_bad <= 1;
                    ld_data <= ld_data + 1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- scoreboard ----------------
    logic [24:0] exp_q [$];

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            results++;
            if (exp_q.size() == 0) begin
                check(0, "R7 unexpected result", 32'(res_row), 0);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                check(res_row == e[24:1], "R7 result row order", 32'(res_row), 32'(e[24:1]));
                check(res_fail == e[0], "R4/R5/R6 fail attribution", 32'(res_fail), 32'(e[0]));
            end
        end
        if (rst_n && abort) aborts++;
    end

    task automatic send_page(input logic [23:0] row, input bit last, input bit push);
        req_row   = row;
        req_last  = last;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        drv_row = row;
        drv_fin = last && end_with_final;
        if (push) exp_q.push_back({row, fail_of(row)});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while ((exp_q.size() != 0 || !req_ready) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, tag, 32'(exp_q.size()), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input bit mode, input logic [23:0] base, input int npages, input string tag);
        end_with_final = mode;
        for (int i = 0; i < npages; i++) send_page(base + 24'(i), i == npages - 1, 1'b1);
        drain(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        hang = 0;
        saw_overlap = 0;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(req_ready == 1, "R10 req_ready in reset", 32'(req_ready), 1);
        check(res_valid == 0 && abort == 0, "R10 no result in reset", 32'({res_valid, abort}), 0);
        check(bus_op == 0 && dat_take == 0, "R10 bus idle in reset", 32'({bus_op, dat_take}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R8: five pages, all cache confirms
        run(1'b0, 24'h000100, 5, "R5 cache-mode run drained");
        check(saw_overlap, "R8 load overlaps array program", 32'(saw_overlap), 1);
        // R6: final opcode mode, multi-byte row
        run(1'b1, 24'h0A0B0C, 4, "R6 final-mode run drained");
        // single pages in both modes
        run(1'b0, 24'h000004, 1, "R5 single page drained");
        run(1'b1, 24'h000005, 1, "R6 single page drained");
        // two pages, previous result from bit 1
        run(1'b1, 24'h000007, 2, "R6 two pages drained");
        run(1'b0, 24'h000010, 2, "R4 two pages drained");
        check(results == 15, "R7 one result per page", 32'(results), 15);

        // R9: cache never frees
        end_with_final = 1'b0;
        send_page(24'h000200, 1'b0, 1'b0);
        send_page(24'h000201, 1'b1, 1'b0);
        hang = 1;
        for (int k = 0; k < 3000 && aborts == 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(aborts == 1, "R9 abort pulses once", 32'(aborts), 1);
        check(results == 15, "R9 pending results dropped", 32'(results), 15);
        check(req_ready == 1, "R9 idle after abort", 32'(req_ready), 1);

        hang = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run(1'b0, 24'h000301, 1, "R9 recovers after abort");
        check(results == 16, "R7 count after recovery", 32'(results), 16);
        finish_run();
    end
endmodule